// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block turns an asynchronous serial line into characters. The line is first passed through a flop synchronizer. A 16x oversampling clock enable then times every decision. Software-visible framing is set by three configuration inputs: data length (5 to 8 bits), parity mode (none, even, odd or forced) and the forced parity value. These are set the same way as the matching transmitter. Each completed character is placed in a one-deep holding register together with parity-error, framing-error, break and overrun flags. It stays there until the consumer pulses `rd_ack`.

Start bits are checked at their midpoint, so glitches shorter than half a bit are dropped. A line that drops low partway through a character first yields that character with a framing error. The receiver then resynchronizes on the still-low line and reports the break as one all-zero character. One-cycle pulses mark the start and the end of the break.

The controlling state machine has six states:
- `S_HUNT` waits for a low sample and goes to `S_START`.
- `S_START` counts to the start-bit midpoint. It returns to `S_HUNT` if the line is high there, and otherwise goes to `S_DATA`.
- `S_DATA` samples each data bit at its centre. After the last bit it goes to `S_PAR` when parity is enabled, and to `S_STOP` when it is not.
- `S_PAR` samples the parity bit and goes to `S_STOP`.
- `S_STOP` samples the stop bit. It goes to `S_BRKWAIT` when the whole frame was zero, and to `S_HUNT` otherwise.
- `S_BRKWAIT` waits for a high sample, then returns to `S_HUNT` and pulses `brk_end`.

Top module: `uart_rx_breakdet`

## Requirements
- R1: Data bits arrive LSB first, sampled at the centre of each bit. `cfg_len` code 0..3 selects 5..8 data bits. The received value is right-aligned on `rx_data` with unused upper bits zero.
- R2: `cfg_par` 0 = no parity bit, 1 = even, 2 = odd, 3 = forced to `cfg_par_force`. A parity bit matching the mode gives `rx_par_err`=0.
- R3: A start bit found high at its midpoint (8th 16x tick after detection) is discarded, produces no character, and does not disturb the next valid character.
- R4: A parity bit that differs from the expected value sets `rx_par_err` on that character.
- R5: A non-break frame whose stop bit is sampled low sets `rx_frm_err`. Its data is still delivered.
- R6: A frame whose data, parity and stop bits are all zero yields exactly one character: data 0, `rx_brk`=1, `rx_frm_err`=0, `rx_par_err`=0. No further character arrives until the line has returned high.
- R7: `brk_start` pulses for one cycle when a break character is delivered. `brk_end` pulses for one cycle when the line then returns high.
- R8: A break beginning in the middle of a character produces that character with `rx_frm_err`=1, followed by a break character.
- R9: `rx_valid` rises when a character completes and stays high until `rd_ack`, which clears it.
- R10: A character completing while `rx_valid` is high and no `rd_ack` is given is discarded. The held character is kept and `rx_overrun` is set; a read clears `rx_overrun`.
- R11: After reset `rx_valid`, `brk_start` and `brk_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_en | input | 1 | 16x oversampling enable |
| rxd_in | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data length code, 0..3 = 5..8 bits |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 forced |
| cfg_par_force | input | 1 | Parity bit value in forced mode |
| rd_ack | input | 1 | Consumer read strobe, clears held character |
| rx_valid | output | 1 | Holding register full |
| rx_data | output | 8 | Received data, right-aligned |
| rx_par_err | output | 1 | Parity error on held character |
| rx_frm_err | output | 1 | Framing error on held character |
| rx_brk | output | 1 | Held character is a break |
| rx_overrun | output | 1 | A newer character was lost |
| brk_start | output | 1 | One-cycle pulse at break detection |
| brk_end | output | 1 | One-cycle pulse when break ends |

## Verification
The bench sweeps every 5-bit value and a spread of 6-, 7- and 8-bit values under all four parity modes. It computes the expected parity arithmetically, so a mis-aligned shift or an inverted parity sense shows up as wrong data or a spurious error. A glitch shorter than half a bit catches a receiver that skips the midpoint check and would emit a garbage character. A stop bit held low only briefly catches a design that restarts on the low stop and frames a phantom character. A break started mid-character catches a receiver that only recognizes breaks aligned to a start bit. A clean long break with odd parity catches one that reports parity or framing errors on a break, or repeats break characters while the line stays low. Two unread characters check that overrun keeps the older data instead of overwriting it.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        S_HUNT,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRKWAIT
    } rx_state_t;

    localparam logic [1:0] PAR_NONE  = 2'd0;
    localparam logic [1:0] PAR_EVEN  = 2'd1;
    localparam logic [1:0] PAR_ODD   = 2'd2;
    localparam logic [1:0] PAR_FORCE = 2'd3;

    typedef struct packed {
        logic par_err;
        logic frm_err;
        logic brk;
    } rx_flags_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_force,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output rx_flags_t         push_flags,
    output logic              brk_end
);
    localparam int CNT_W    = $clog2(OVS);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int MIN_BITS = DATA_W - 3;
    localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] END_CNT = CNT_W'(OVS - 1);

    rx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q;
    logic              parbit_q;

    logic              at_mid, at_end, par_en, is_brk, exp_par;
    logic [IDX_W-1:0]  last_idx, shamt;

    assign at_mid   = (cnt_q == MID_CNT);
    assign at_end   = (cnt_q == END_CNT);
    assign par_en   = (cfg_par != PAR_NONE);
    assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_len);
    assign shamt    = IDX_W'(DATA_W - MIN_BITS) - IDX_W'(cfg_len);
    assign is_brk   = (sh_q == '0) && !parbit_q && !rx;

    always_comb begin
        unique case (cfg_par)
            PAR_EVEN: exp_par = ^sh_q;
            PAR_ODD:  exp_par = ~^sh_q;
            PAR_FORCE: exp_par = cfg_force;
            default:  exp_par = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HUNT:    if (tick && !rx) state_d = S_START;
            S_START:   if (tick && at_mid) state_d = rx ? S_HUNT : S_DATA;
            S_DATA:    if (tick && at_end && idx_q == last_idx)
                           state_d = par_en ? S_PAR : S_STOP;
            S_PAR:     if (tick && at_end) state_d = S_STOP;
            S_STOP:    if (tick && at_end) state_d = is_brk ? S_BRKWAIT : S_HUNT;
            S_BRKWAIT: if (tick && rx) state_d = S_HUNT;
            default:   state_d = S_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HUNT;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            idx_q      <= '0;
            sh_q       <= '0;
            parbit_q   <= 1'b0;
            push       <= 1'b0;
            push_data  <= '0;
            push_flags <= '0;
            brk_end    <= 1'b0;
        end else begin
            push    <= 1'b0;
            brk_end <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    S_HUNT: begin
                        cnt_q    <= '0;
                        idx_q    <= '0;
                        sh_q     <= '0;
                        parbit_q <= 1'b0;
                    end
                    S_START: begin
                        cnt_q <= at_mid ? '0 : cnt_q + 1'b1;
                    end
                    S_DATA: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (at_end) begin
                            sh_q  <= {rx, sh_q[DATA_W-1:1]};
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    S_PAR: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (at_end) parbit_q <= rx;
                    end
                    S_STOP: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (at_end) begin
                            push               <= 1'b1;
                            push_data          <= sh_q >> shamt;
                            push_flags.brk     <= is_brk;
                            push_flags.frm_err <= !rx && !is_brk;
                            push_flags.par_err <= par_en && (parbit_q != exp_par) && !is_brk;
                        end
                    end
                    S_BRKWAIT: begin
                        if (rx) brk_end <= 1'b1;
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START && tick && at_mid && rx) |=> (state_q == S_HUNT && !push)); // R3
    AST_BRK_CLEAN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_flags.brk) |-> (push_data == '0 && !push_flags.frm_err && !push_flags.par_err)); // R6
    AST_BRK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BRKWAIT && !rx) |=> (state_q == S_BRKWAIT && !push)); // R6
    AST_BRK_END_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |=> !brk_end); // R7
endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  rx_flags_t         push_flags,
    input  logic              rd_ack,
    output logic              valid_q,
    output logic [DATA_W-1:0] data_q,
    output rx_flags_t         flags_q,
    output logic              ovr_q
);
    logic room;
    assign room = !valid_q || rd_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            flags_q <= '0;
            ovr_q   <= 1'b0;
        end else if (push && room) begin
            valid_q <= 1'b1;
            data_q  <= push_data;
            flags_q <= push_flags;
            ovr_q   <= 1'b0;
        end else if (push) begin
            ovr_q   <= 1'b1;
        end else if (rd_ack) begin
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
        end
    end

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && push && !rd_ack) |=> (ovr_q && data_q == $past(data_q))); // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !push) |=> !valid_q); // R9
    AST_PUSH_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> valid_q); // R9
endmodule

// File: rtl/uart_rx_breakdet.sv
module uart_rx_breakdet
    import srx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16_en,
    input  logic              rxd_in,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_par_force,
    input  logic              rd_ack,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_par_err,
    output logic              rx_frm_err,
    output logic              rx_brk,
    output logic              rx_overrun,
    output logic              brk_start,
    output logic              brk_end
);
    logic              rx_s;
    logic              push;
    logic [DATA_W-1:0] push_data;
    rx_flags_t         push_flags;
    rx_flags_t         held_flags;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rxd_in),
        .q_out (rx_s)
    );

    srx_frame_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16_en),
        .rx         (rx_s),
        .cfg_len    (cfg_len),
        .cfg_par    (cfg_par),
        .cfg_force  (cfg_par_force),
        .push       (push),
        .push_data  (push_data),
        .push_flags (push_flags),
        .brk_end    (brk_end)
    );

    srx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_data  (push_data),
        .push_flags (push_flags),
        .rd_ack     (rd_ack),
        .valid_q    (rx_valid),
        .data_q     (rx_data),
        .flags_q    (held_flags),
        .ovr_q      (rx_overrun)
    );

    assign brk_start  = push && push_flags.brk;
    assign rx_par_err = held_flags.par_err;
    assign rx_frm_err = held_flags.frm_err;
    assign rx_brk     = held_flags.brk;

    AST_BRK_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |=> !brk_start); // R7
endmodule

// File: tb/tb_uart_rx_breakdet.sv
module tb_uart_rx_breakdet;
    localparam int TDIV   = 2;
    localparam int BITCLK = 16 * TDIV;
    localparam int WDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_force = 1'b0;
    logic       rd_ack = 1'b0;
    logic       rx_valid, rx_par_err, rx_frm_err, rx_brk, rx_overrun, brk_start, brk_end;
    logic [7:0] rx_data;

    int n_chk = 0, n_fail = 0, n_bs = 0, n_be = 0, cyc = 0, tcnt = 0;

    uart_rx_breakdet dut (
        .clk(clk), .rst_n(rst_n), .tick16_en(tick), .rxd_in(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_par_force(cfg_force),
        .rd_ack(rd_ack), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
        .rx_overrun(rx_overrun), .brk_start(brk_start), .brk_end(brk_end)
    );

    always #5 clk = ~clk;
    assign tick = (tcnt == 0);

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
        if (rst_n && brk_start) n_bs <= n_bs + 1;
        if (rst_n && brk_end)   n_be <= n_be + 1;
    end

    always @(posedge clk) begin
        if (cyc == WDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_par(int d, int pm, int fv);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += (d >> i) & 1;
        if (pm == 1) return ones % 2;
        if (pm == 2) return 1 - (ones % 2);
        return fv;
    endfunction

    task automatic drive(int v, int nclk);
        rxd = v[0];
        repeat (nclk) @(negedge clk);
    endtask

    task automatic send(int d, int nb, int pm, int fv, int bad_par, int stop_v, int stop_clk);
        drive(0, BITCLK);
        for (int i = 0; i < nb; i++) drive((d >> i) & 1, BITCLK);
        if (pm != 0) drive(exp_par(d, pm, fv) ^ bad_par, BITCLK);
        drive(stop_v, stop_clk);
        drive(1, 2 * BITCLK);
    endtask

    task automatic expect_char(string req, int d, int pe, int fe, int bk, int ov);
        check({req, " valid"}, int'(rx_valid), 1);
        check({req, " data"}, int'(rx_data), d);
        check({req, " par_err"}, int'(rx_par_err), pe);
        check({req, " frm_err"}, int'(rx_frm_err), fe);
        check({req, " brk"}, int'(rx_brk), bk);
        check({req, " overrun"}, int'(rx_overrun), ov);
    endtask

    task automatic ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_valid(int lim);
        int k = 0;
        while (!rx_valid && k < lim) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R11 valid in reset", int'(rx_valid), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 valid after reset", int'(rx_valid), 0);
        check("R11 brk_start after reset", int'(brk_start), 0);
        check("R11 brk_end after reset", int'(brk_end), 0);

        // R1 R2: sweep lengths and parity modes
        for (int nb = 5; nb <= 8; nb++) begin
            for (int pm = 0; pm < 4; pm++) begin
                int cnt = (nb == 5) ? 32 : 8;
                cfg_len = 2'(nb - 5);
                cfg_par = 2'(pm);
                for (int k = 0; k < cnt; k++) begin
                    int mask = (1 << nb) - 1;
                    int d = (nb == 5) ? k : ((k * 37 + 11) & mask);
                    cfg_force = 1'(k & 1);
                    send(d, nb, pm, k & 1, 0, 1, BITCLK);
                    expect_char("R1 R2 sweep", d, 0, 0, 0, 0);
                    ack();
                end
            end
        end

        // R4: parity errors in each parity-bearing mode
        cfg_len = 2'd3;
        cfg_par = 2'd1; cfg_force = 1'b0;
        send(8'h3C, 8, 1, 0, 1, 1, BITCLK);
        expect_char("R4 even bad", 8'h3C, 1, 0, 0, 0); ack();
        cfg_par = 2'd2;
        send(8'h01, 8, 2, 0, 1, 1, BITCLK);
        expect_char("R4 odd bad", 8'h01, 1, 0, 0, 0); ack();
        cfg_par = 2'd3; cfg_force = 1'b1;
        send(8'hF0, 8, 3, 1, 1, 1, BITCLK);
        expect_char("R4 forced bad", 8'hF0, 1, 0, 0, 0); ack();

        // R5: framing error, stop low for 12 ticks only
        cfg_len = 2'd2; cfg_par = 2'd1;
        send(8'h55, 7, 1, 0, 0, 0, 24);
        expect_char("R5 framing", 8'h55, 0, 1, 0, 0); ack();
        drive(1, 2 * BITCLK);
        check("R5 no phantom char", int'(rx_valid), 0);

        // R3: false start glitch of 3 ticks
        cfg_len = 2'd3; cfg_par = 2'd0;
        drive(0, 6);
        drive(1, 3 * BITCLK);
        check("R3 glitch ignored", int'(rx_valid), 0);
        send(8'hA5, 8, 0, 0, 0, 1, BITCLK);
        expect_char("R3 next char intact", 8'hA5, 0, 0, 0, 0); ack();

        // R6 R7: clean break with odd parity
        cfg_len = 2'd1; cfg_par = 2'd2;
        drive(0, 12 * BITCLK);
        expect_char("R6 break char", 0, 0, 0, 1, 0);
        check("R7 brk_start count", n_bs, 1);
        check("R7 no brk_end while low", n_be, 0);
        ack();
        drive(0, 8 * BITCLK);
        check("R6 single break char", int'(rx_valid), 0);
        drive(1, 2 * BITCLK);
        check("R7 brk_end count", n_be, 1);
        check("R6 none after release", int'(rx_valid), 0);

        // R8: break beginning mid-character
        cfg_len = 2'd3; cfg_par = 2'd0;
        fork
            begin
                drive(0, BITCLK);
                drive(1, BITCLK);
                drive(1, BITCLK);
                drive(0, 30 * BITCLK);
                drive(1, 2 * BITCLK);
            end
            begin
                wait_valid(20 * BITCLK);
                expect_char("R8 cut char", 3, 0, 1, 0, 0);
                ack();
                wait_valid(20 * BITCLK);
                expect_char("R8 break char", 0, 0, 0, 1, 0);
                ack();
            end
        join
        check("R8 brk_start total", n_bs, 2);
        check("R8 brk_end total", n_be, 2);

        // R9 R10: overrun keeps older character
        send(8'h11, 8, 0, 0, 0, 1, BITCLK);
        send(8'h22, 8, 0, 0, 0, 1, BITCLK);
        expect_char("R10 overrun", 8'h11, 0, 0, 0, 1);
        ack();
        check("R9 read clears valid", int'(rx_valid), 0);
        check("R10 read clears overrun", int'(rx_overrun), 0);
        send(8'h33, 8, 0, 0, 0, 1, BITCLK);
        expect_char("R9 after read", 8'h33, 0, 0, 0, 0);
        ack();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule